// File: doc/BRIEF.md
# Iterative Integer Multiply and Multiply-Add Unit

This unit multiplies two XLEN-bit integers over several clock cycles and returns one XLEN-bit slice of the result. It covers low-half products with overflow detection, high-half products in signed and unsigned flavours, half-width (word) products, and multiply-add forms that add a third operand to the full double-width product before a half is picked. A requester drives the operands, an operation code and two modifier flags: an overflow-enable and a record flag. It pulses `start` while the unit is idle and waits for the one-cycle `done` pulse.

Internally the operands are first sign- or zero-extended as the operation requires. They are then turned into magnitudes with a product sign. An iterative shift-add engine retires `STEP_BITS` multiplier bits per clock, with one or two bits chosen at elaboration. A final stage restores the sign on the double-width product, adds the addend and selects the result field. The record flag adds a three-bit signed comparison of the result against zero.

Top module: `int_muladd_unit`

## Requirements
- R1: While `rst_n` is low and after its release, `busy`, `done`, `overflow`, `flags` and `result` are all zero until the first operation completes.
- R2: A `start` seen in idle raises `busy` on the next cycle. The single-cycle `done` pulse comes XLEN/STEP_BITS+1 clock edges after the edge that captured `start`. `busy` is low while `done` is high.
- R3: A `start` seen while `busy` is high is ignored. The running operation completes on its own schedule, with its own operands.
- R4: Code 0 (low signed) returns bits XLEN-1..0 of the signed product of `src_a` and `src_b`. With `ovf_en`=1, `overflow` is set when product bits 2*XLEN-1..XLEN-1 are neither all zero nor all one.
- R5: Code 1 returns the upper XLEN bits of the signed product. Code 2 returns the upper XLEN bits of the unsigned product.
- R6: Code 3 multiplies the low halves (XLEN/2 bits) of both operands as signed values and returns the full XLEN-bit product. With `ovf_en`=1, `overflow` is set when product bits XLEN-1..XLEN/2-1 are not all equal.
- R7: Codes 4 (signed) and 5 (unsigned) multiply the low halves of both operands and place the upper half of the XLEN-bit product in both halves of `result`.
- R8: Codes 6 and 8 add `src_c`, sign-extended to 2*XLEN bits, to the signed product; code 6 returns the upper XLEN bits of the sum and code 8 the lower XLEN bits. Code 7 adds `src_c`, zero-extended, to the unsigned product and returns the upper XLEN bits.
- R9: Code 9 multiplies `src_a` by the low IMM_W bits of `src_b`, sign-extended, and returns the low XLEN bits. The upper bits of `src_b` have no effect.
- R10: `overflow` is zero whenever `ovf_en`=0, and for every code other than 0 and 3. Codes 10 to 15 return a zero result.
- R11: With `rec`=1, `flags` = {bit2: result negative, bit1: result positive and nonzero, bit0: result zero}, with the result read as a signed value. With `rec`=0, `flags` is zero.
- R12: `result`, `overflow` and `flags` keep their values from one `done` pulse to the next, whatever the inputs do in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| op_sel | input | 4 | Operation code, 0 to 9 (see requirements) |
| ovf_en | input | 1 | Enable overflow reporting |
| rec | input | 1 | Enable the comparison flags |
| src_a | input | XLEN | Multiplicand |
| src_b | input | XLEN | Multiplier, or immediate in its low IMM_W bits |
| src_c | input | XLEN | Addend for the multiply-add codes |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: outputs updated |
| result | output | XLEN | Selected result field |
| overflow | output | 1 | Overflow indication |
| flags | output | 3 | {negative, positive, zero} of the result |

## Verification
With the default two bits per step, `busy` is due one edge after the capture edge and `done` is due 33 edges after it. `result`, `overflow` and `flags` are valid from that same edge until the next pulse. The bench drives inputs on falling edges and counts rising edges from the capture edge until it first sees `done` high at a falling edge. It compares that count with XLEN/STEP_BITS+2, since the count includes the capture edge, and reads the outputs in that same half-cycle. It checks `busy` at the first falling edge after capture and checks that `done` is low one cycle after the pulse.

// File: rtl/muladd_pkg.sv
package muladd_pkg;

   typedef enum logic [3:0] {
      OP_LO        = 4'd0,
      OP_HI_S      = 4'd1,
      OP_HI_U      = 4'd2,
      OP_W_LO      = 4'd3,
      OP_W_HI_S    = 4'd4,
      OP_W_HI_U    = 4'd5,
      OP_MADD_HI_S = 4'd6,
      OP_MADD_HI_U = 4'd7,
      OP_MADD_LO   = 4'd8,
      OP_IMM       = 4'd9
   } mul_op_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIN  = 2'd2
   } mul_state_e;

   function automatic logic op_is_signed(mul_op_e op);
      return !(op == OP_HI_U || op == OP_W_HI_U || op == OP_MADD_HI_U);
   endfunction

endpackage

// File: rtl/muladd_operand_prep.sv
module muladd_operand_prep
   import muladd_pkg::*;
#(
   parameter int XLEN  = 64,
   parameter int IMM_W = 16
) (
   input  mul_op_e           op,
   input  logic [XLEN-1:0]   a,
   input  logic [XLEN-1:0]   b,
   output logic [XLEN-1:0]   mag_a,
   output logic [XLEN-1:0]   mag_b,
   output logic              neg
);
   localparam int HALF = XLEN / 2;

   logic [XLEN-1:0] ext_a, ext_b;
   logic            sgn, sa, sb;

   always_comb begin
      ext_a = a;
      ext_b = b;
      case (op)
         OP_W_LO, OP_W_HI_S: begin
            ext_a = {{HALF{a[HALF-1]}}, a[HALF-1:0]};
            ext_b = {{HALF{b[HALF-1]}}, b[HALF-1:0]};
         end
         OP_W_HI_U: begin
            ext_a = {{HALF{1'b0}}, a[HALF-1:0]};
            ext_b = {{HALF{1'b0}}, b[HALF-1:0]};
         end
         OP_IMM: ext_b = {{(XLEN-IMM_W){b[IMM_W-1]}}, b[IMM_W-1:0]};
         default: ;
      endcase
      sgn   = op_is_signed(op);
      sa    = sgn & ext_a[XLEN-1];
      sb    = sgn & ext_b[XLEN-1];
      mag_a = sa ? (~ext_a + 1'b1) : ext_a;
      mag_b = sb ? (~ext_b + 1'b1) : ext_b;
      neg   = sa ^ sb;
   end

endmodule

// File: rtl/muladd_iter_core.sv
module muladd_iter_core #(
   parameter int XLEN      = 64,
   parameter int STEP_BITS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              step,
   input  logic [XLEN-1:0]   mcand_in,
   input  logic [XLEN-1:0]   mplier_in,
   output logic [2*XLEN-1:0] prod,
   output logic              last
);
   localparam int PW    = 2 * XLEN;
   localparam int STEPS = XLEN / STEP_BITS;
   localparam int CNT_W = $clog2(STEPS + 1);

   logic [PW-1:0]    acc, mcand, pp;
   logic [XLEN-1:0]  mplier;
   logic [CNT_W-1:0] cnt;

   generate
      if (STEP_BITS == 1) begin : g_radix2
         assign pp = mplier[0] ? mcand : '0;
      end else begin : g_radix4
         always_comb begin
            case (mplier[1:0])
               2'd0:    pp = '0;
               2'd1:    pp = mcand;
               2'd2:    pp = mcand << 1;
               default: pp = mcand + (mcand << 1);
            endcase
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc    <= '0;
         mcand  <= '0;
         mplier <= '0;
         cnt    <= '0;
      end else if (load) begin
         acc    <= '0;
         mcand  <= {{XLEN{1'b0}}, mcand_in};
         mplier <= mplier_in;
         cnt    <= '0;
      end else if (step) begin
         acc    <= acc + pp;
         mcand  <= mcand << STEP_BITS;
         mplier <= mplier >> STEP_BITS;
         cnt    <= cnt + 1'b1;
      end
   end

   assign prod = acc;
   assign last = (cnt == CNT_W'(STEPS - 1));

   p_no_overrun_r2: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> (cnt < CNT_W'(STEPS)));
   p_load_step_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(load && step));

endmodule

// File: rtl/muladd_finish.sv
module muladd_finish
   import muladd_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  mul_op_e           op,
   input  logic              neg,
   input  logic [2*XLEN-1:0] prod_mag,
   input  logic [XLEN-1:0]   addend_src,
   input  logic              oe,
   input  logic              rec,
   output logic [XLEN-1:0]   res,
   output logic              ovf,
   output logic [2:0]        flg
);
   localparam int PW   = 2 * XLEN;
   localparam int HALF = XLEN / 2;

   logic [PW-1:0] prod_s, addend, sum;

   always_comb begin
      prod_s = neg ? (~prod_mag + 1'b1) : prod_mag;
      case (op)
         OP_MADD_HI_S, OP_MADD_LO: addend = {{XLEN{addend_src[XLEN-1]}}, addend_src};
         OP_MADD_HI_U:             addend = {{XLEN{1'b0}}, addend_src};
         default:                  addend = '0;
      endcase
      sum = prod_s + addend;

      case (op)
         OP_LO, OP_IMM, OP_MADD_LO, OP_W_LO:           res = sum[XLEN-1:0];
         OP_HI_S, OP_HI_U, OP_MADD_HI_S, OP_MADD_HI_U: res = sum[PW-1:XLEN];
         OP_W_HI_S, OP_W_HI_U:                         res = {2{sum[XLEN-1:HALF]}};
         default:                                      res = '0;
      endcase

      case (op)
         OP_LO:   ovf = oe & ~((&sum[PW-1:XLEN-1]) | ~(|sum[PW-1:XLEN-1]));
         OP_W_LO: ovf = oe & ~((&sum[XLEN-1:HALF-1]) | ~(|sum[XLEN-1:HALF-1]));
         default: ovf = 1'b0;
      endcase

      flg = rec ? {res[XLEN-1], ~res[XLEN-1] & (|res), ~(|res)} : 3'b000;
   end

   always_comb begin
      p_flags_onehot_r11: assert ($onehot0(flg));
   end

endmodule

// File: rtl/int_muladd_unit.sv
module int_muladd_unit
   import muladd_pkg::*;
#(
   parameter int XLEN      = 64,
   parameter int STEP_BITS = 2,
   parameter int IMM_W     = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [3:0]      op_sel,
   input  logic            ovf_en,
   input  logic            rec,
   input  logic [XLEN-1:0] src_a,
   input  logic [XLEN-1:0] src_b,
   input  logic [XLEN-1:0] src_c,
   output logic            busy,
   output logic            done,
   output logic [XLEN-1:0] result,
   output logic            overflow,
   output logic [2:0]      flags
);
   localparam int HALF = XLEN / 2;

   generate
      if (STEP_BITS != 1 && STEP_BITS != 2) begin : g_bad_step
         $error("STEP_BITS must be 1 or 2");
      end
      if (XLEN % 2 != 0 || XLEN < 4) begin : g_bad_xlen
         $error("XLEN must be even and at least 4");
      end
      if (IMM_W < 1 || IMM_W > XLEN) begin : g_bad_imm
         $error("IMM_W must lie in 1..XLEN");
      end
   endgenerate

   mul_state_e       state;
   mul_op_e          op_in, op_q;
   logic             oe_q, rec_q, neg_q, neg_in;
   logic [XLEN-1:0]  c_q, mag_a, mag_b, fin_res;
   logic [2*XLEN-1:0] prod;
   logic             last, load, step, fin_ovf;
   logic [2:0]       fin_flg;

   assign op_in = mul_op_e'(op_sel);
   assign load  = (state == ST_IDLE) && start;
   assign step  = (state == ST_RUN);
   assign busy  = (state != ST_IDLE);

   muladd_operand_prep #(.XLEN(XLEN), .IMM_W(IMM_W)) u_prep (
      .op(op_in), .a(src_a), .b(src_b),
      .mag_a(mag_a), .mag_b(mag_b), .neg(neg_in)
   );

   muladd_iter_core #(.XLEN(XLEN), .STEP_BITS(STEP_BITS)) u_core (
      .clk(clk), .rst_n(rst_n), .load(load), .step(step),
      .mcand_in(mag_a), .mplier_in(mag_b), .prod(prod), .last(last)
   );

   muladd_finish #(.XLEN(XLEN)) u_fin (
      .op(op_q), .neg(neg_q), .prod_mag(prod), .addend_src(c_q),
      .oe(oe_q), .rec(rec_q), .res(fin_res), .ovf(fin_ovf), .flg(fin_flg)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         op_q     <= OP_LO;
         oe_q     <= 1'b0;
         rec_q    <= 1'b0;
         neg_q    <= 1'b0;
         c_q      <= '0;
         done     <= 1'b0;
         result   <= '0;
         overflow <= 1'b0;
         flags    <= 3'b000;
      end else begin
         done <= 1'b0;
         case (state)
            ST_IDLE: if (start) begin
               op_q  <= op_in;
               oe_q  <= ovf_en;
               rec_q <= rec;
               neg_q <= neg_in;
               c_q   <= src_c;
               state <= ST_RUN;
            end
            ST_RUN: if (last) state <= ST_FIN;
            ST_FIN: begin
               result   <= fin_res;
               overflow <= fin_ovf;
               flags    <= fin_flg;
               done     <= 1'b1;
               state    <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_busy_done_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   p_start_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> ($stable(op_q) && $stable(c_q) && $stable(neg_q)));
   p_ovf_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (done && overflow) |-> (oe_q && (op_q == OP_LO || op_q == OP_W_LO)));
   p_word_dup_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && (op_q == OP_W_HI_S || op_q == OP_W_HI_U))
         |-> (result[XLEN-1:HALF] == result[HALF-1:0]));
   p_flags_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !rec_q) |-> (flags == 3'b000));
   p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_FIN) |=> ($stable(result) && $stable(overflow) && $stable(flags)));

endmodule

// File: tb/sim_int_muladd_unit.sv
module sim_int_muladd_unit;
   localparam int XLEN = 64;
   localparam int STEP_BITS = 2;
   localparam int EXP_EDGES = XLEN / STEP_BITS + 2;
   localparam int NV = 20;
   localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

   localparam logic [3:0] V_OP [NV] = '{0,0,0,0,0,0,1,2,1,3,3,4,5,6,7,8,6,9,9,12};
   localparam logic [63:0] V_A [NV] = '{
      64'd3, 64'hFFFF_FFFF_FFFF_FFFE, 64'h4000_0000_0000_0000, 64'h4000_0000_0000_0000,
      64'h8000_0000_0000_0000, ONES, ONES, ONES,
      64'h8000_0000_0000_0000, 64'hDEAD_0000_FFFF_FFFF, 64'h0000_0000_4000_0000, 64'h0000_0000_FFFF_FFFF,
      64'h0000_0000_FFFF_FFFF, ONES, ONES, 64'h4000_0000_0000_0000,
      64'h4000_0000_0000_0000, 64'd10, 64'h4000_0000_0000_0000, 64'd3};
   localparam logic [63:0] V_B [NV] = '{
      64'd5, 64'd3, 64'd2, 64'd2,
      ONES, ONES, 64'd1, 64'd2,
      64'h8000_0000_0000_0000, 64'h1234_0000_0000_0005, 64'd2, 64'd2,
      64'd2, 64'd1, 64'd1, 64'd4,
      64'd4, 64'h1234_5678_0000_FFFE, 64'd2, 64'd5};
   localparam logic [63:0] V_C [NV] = '{
      64'd0, 64'd0, 64'd0, 64'd0, 64'd0, 64'd0, 64'd0, 64'd0, 64'd0, 64'd0,
      64'd0, 64'd0, 64'd0, 64'd1, 64'd1, ONES, ONES, 64'd0, 64'd0, 64'd0};
   localparam logic V_OE  [NV] = '{1,0,1,0,1,1,1,0,0,1,1,0,0,0,0,0,0,1,1,1};
   localparam logic V_REC [NV] = '{1,1,0,0,0,1,1,1,0,1,0,0,0,1,0,1,1,0,0,1};
   localparam logic [63:0] V_RES [NV] = '{
      64'd15, 64'hFFFF_FFFF_FFFF_FFFA, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000,
      64'h8000_0000_0000_0000, 64'd1, ONES, 64'd1,
      64'h4000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFB, 64'h0000_0000_8000_0000, ONES,
      64'h0000_0001_0000_0001, 64'd0, 64'd1, ONES,
      64'd0, 64'hFFFF_FFFF_FFFF_FFEC, 64'h8000_0000_0000_0000, 64'd0};
   localparam logic V_OVF [NV] = '{0,0,1,0,1,0,0,0,0,0,1,0,0,0,0,0,0,0,0,0};
   localparam logic [2:0] V_FLG [NV] = '{3'b010,3'b100,3'b000,3'b000,3'b000,3'b010,3'b100,3'b010,
      3'b000,3'b100,3'b000,3'b000,3'b000,3'b001,3'b000,3'b100,3'b001,3'b000,3'b000,3'b001};
   localparam string V_REQ [NV] = '{"R4","R4","R4","R10","R4","R4","R5","R5","R5","R6",
      "R6","R7","R7","R8","R8","R8","R8","R9","R9","R10"};

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, ovf_en = 1'b0, rec = 1'b0;
   logic [3:0] op_sel = '0;
   logic [63:0] src_a = '0, src_b = '0, src_c = '0;
   logic busy, done, overflow;
   logic [63:0] result;
   logic [2:0] flags;
   int n_chk = 0, n_fail = 0, cyc = 0;

   always #4 clk = ~clk;

   int_muladd_unit #(.XLEN(XLEN), .STEP_BITS(STEP_BITS), .IMM_W(16)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel), .ovf_en(ovf_en),
      .rec(rec), .src_a(src_a), .src_b(src_b), .src_c(src_c), .busy(busy),
      .done(done), .result(result), .overflow(overflow), .flags(flags));

   task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         chk(1'b0, "watchdog", 64'(cyc), 64'd150000);
         finish_run();
      end
   end

   task automatic drive(input logic [3:0] op, input logic [63:0] a, input logic [63:0] b,
                        input logic [63:0] c, input logic oe, input logic rc);
      op_sel = op; src_a = a; src_b = b; src_c = c; ovf_en = oe; rec = rc;
   endtask

   // Start at a falling edge; returns rising edges counted through the done edge.
   task automatic launch_and_wait(input int interfere_at, output int edges);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      edges = 1;
      chk(busy === 1'b1, "R2 busy after start", 64'(busy), 64'd1);
      while (done !== 1'b1 && edges < 200) begin
         if (edges == interfere_at) begin
            drive(4'd1, 64'd7, 64'd9, 64'd0, 1'b0, 1'b0);
            start = 1'b1;
         end
         @(negedge clk);
         start = 1'b0;
         edges++;
      end
   endtask

   initial begin
      int edges;
      // R1: reset state
      repeat (3) @(negedge clk);
      chk(busy === 1'b0 && done === 1'b0, "R1 busy/done in reset", {busy, done}, 64'd0);
      chk(result === 64'd0 && overflow === 1'b0 && flags === 3'b000, "R1 outputs in reset",
          result, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(result === 64'd0 && busy === 1'b0, "R1 after release", result, 64'd0);

      for (int i = 0; i < NV; i++) begin
         drive(V_OP[i], V_A[i], V_B[i], V_C[i], V_OE[i], V_REC[i]);
         launch_and_wait(-1, edges);
         chk(edges == EXP_EDGES, "R2 latency", 64'(edges), 64'(EXP_EDGES));
         chk(busy === 1'b0, "R2 busy low with done", 64'(busy), 64'd0);
         chk(result === V_RES[i], V_REQ[i], result, V_RES[i]);
         chk(overflow === V_OVF[i], (V_OVF[i] || V_OE[i]) ? "R10 overflow" : "R4 overflow",
             64'(overflow), 64'(V_OVF[i]));
         chk(flags === V_FLG[i], "R11 flags", 64'(flags), 64'(V_FLG[i]));
         @(negedge clk);
         chk(done === 1'b0, "R2 single pulse", 64'(done), 64'd0);
      end

      // R3: start during a running operation is ignored
      drive(4'd0, 64'd3, 64'd5, 64'd0, 1'b0, 1'b1);
      launch_and_wait(6, edges);
      chk(edges == EXP_EDGES, "R3 latency unchanged", 64'(edges), 64'(EXP_EDGES));
      chk(result === 64'd15, "R3 first operands kept", result, 64'd15);
      chk(flags === 3'b010, "R3 first flags kept", 64'(flags), 64'b010);

      // R12: outputs hold with changing inputs and no start
      drive(4'd2, ONES, ONES, ONES, 1'b1, 1'b0);
      repeat (12) @(negedge clk);
      chk(result === 64'd15 && done === 1'b0 && busy === 1'b0, "R12 hold", result, 64'd15);
      chk(flags === 3'b010 && overflow === 1'b0, "R12 flags hold", 64'(flags), 64'b010);

      // R9: upper bits of the immediate operand have no effect
      drive(4'd9, 64'd10, 64'hFFFF_0000_0000_0003, 64'd0, 1'b0, 1'b0);
      launch_and_wait(-1, edges);
      chk(result === 64'd30, "R9 upper immediate bits ignored", result, 64'd30);

      finish_run();
   end
endmodule